// File: doc/BRIEF.md
# Translation Table Bulk Update Sequencer

This block carries out multi-page update commands against an I/O translation table by driving the table's single-entry write port one page at a time. It supports two commands. A fill command writes a single 64-bit value into a run of consecutive page entries. A list command fetches 64-bit entries one at a time from a list in system memory and writes them to consecutive pages. It uses a read port that allows only one outstanding request.

A command carries the following fields:
- a 64-bit window identifier;
- a starting bus address;
- an operand, which is either the fill value or the list address;
- a page count.

The block checks the command against the configuration of the addressed window before it touches anything. It then walks the pages and stops at the first write that the table refuses. When the command finishes, it pulses `done` and reports a status together with the index of the last entry that was written successfully. The window configuration comes in on static inputs: an identifier, an entry count and a page-size exponent for each window. The table storage, and its bounds check on each write, sit outside this block.

Top module: `tce_bulk_seq`

## Requirements
- R1: A command is rejected if the upper 32 bits of its window identifier are nonzero, or if its lower 32 bits match no configured window identifier. A rejected command produces status 1, reported index 0, no table write and no memory read.
- R2: A fill command (cmd_kind = 0) whose page count is larger than the selected window's entry count is rejected with status 1, and no write is made.
- R3: A list command (cmd_kind = 1) is rejected with status 1, and with no read or write, in either of two cases: its page count is above MAX_LIST (512), or its list address has any of bits [11:0] set.
- R4: A page count of zero completes with status 1, reported index 0, and no write.
- R5: The first write goes to the starting bus address rounded down to the selected window's page size (2^shift). Write k goes to that rounded address plus k·2^shift.
- R6: A fill command writes the operand value unchanged into every page it writes.
- R7: For list entry k, the block issues one read at list address + 8k. It holds rd_req and rd_addr steady until rd_ack, and it never has a second read outstanding. rd_data carries the memory byte at the lowest address in bits [7:0]. The list entries are big-endian, so the value written is rd_data with its bytes reversed.
- R8: A write answered with tw_err in the same cycle ends the command: that write is the last one, and the status is 1.
- R9: When every write succeeds, the status is 0 and the reported index is count−1. When write k fails, the reported index is k−1, or 0 if k = 0.
- R10: For each accepted command, done is a single-cycle pulse. cmd_ready is high only while the block is idle. Status encoding: 0 = success, 1 = parameter error.
- R11: tw_sel gives the position of the matching window in the configuration vectors. If two windows carry the same identifier, the lower position is chosen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present; taken while cmd_ready is high |
| cmd_ready | output | 1 | Block idle, ready to take a command |
| cmd_kind | input | 1 | 0 = fill, 1 = list |
| cmd_window | input | 64 | Window identifier |
| cmd_bus_addr | input | 64 | Starting bus address |
| cmd_operand | input | 64 | Fill value or list address |
| cmd_count | input | CNT_W | Number of pages |
| done | output | 1 | One-cycle completion pulse |
| status | output | 1 | 0 success, 1 parameter error; valid with done |
| last_index | output | CNT_W | Last successful entry index; valid with done |
| win_ids | input | NUM_WIN*32 | Window identifiers, window 0 in the low bits |
| win_sizes | input | NUM_WIN*CNT_W | Entry count for each window |
| win_shifts | input | NUM_WIN*6 | Page-size exponent for each window |
| tw_en | output | 1 | Table write strobe |
| tw_sel | output | SEL_W | Selected window |
| tw_addr | output | 64 | Page-aligned bus address of the entry |
| tw_data | output | 64 | Entry value |
| tw_err | input | 1 | Table refuses the write (same cycle) |
| rd_req | output | 1 | Memory read request |
| rd_addr | output | 64 | Read address |
| rd_ack | input | 1 | Request accepted |
| rd_valid | input | 1 | Read data strobe |
| rd_data | input | 64 | Read data, lowest-address byte in [7:0] |

## Verification
The bench builds the block with two windows. The first holds 8 entries of 4 KiB pages and the second holds 4 entries of 64 KiB pages at a nonzero base, which keeps the table edge only a few pages from any starting point. With the table this small, a sweep over every starting page and every count from 0 to 9 for fills, and from 0 to 6 for lists, reaches a large set of cases: clean completion, a stop at the first, middle or last entry, and counts that exceed the fill limit. Separate commands cover bad window identifiers, misaligned list addresses, the 512/513 list-count edge and a start below the window base.

// File: rtl/tce_seq_pkg.sv
package tce_seq_pkg;
  localparam int ADDR_W = 64;
  localparam int SH_W   = 6;

  typedef enum logic [1:0] {SQ_IDLE, SQ_REQ, SQ_WAIT, SQ_WRITE} seq_state_e;

  localparam logic KIND_FILL = 1'b0;
  localparam logic KIND_LIST = 1'b1;
  localparam logic ST_OK     = 1'b0;
  localparam logic ST_PARAM  = 1'b1;

  // Page size for a given exponent.
  function automatic logic [ADDR_W-1:0] page_step(input logic [SH_W-1:0] sh);
    return {{(ADDR_W-1){1'b0}}, 1'b1} << sh;
  endfunction

  // Round an address down to its page boundary.
  function automatic logic [ADDR_W-1:0] page_base(input logic [ADDR_W-1:0] a,
                                                  input logic [SH_W-1:0] sh);
    return a & ~(page_step(sh) - 1'b1);
  endfunction

  // Reverse byte order of a 64-bit word (memory order to big-endian value).
  function automatic logic [63:0] byte_rev(input logic [63:0] d);
    logic [63:0] r;
    for (int b = 0; b < 8; b++) r[8*b +: 8] = d[8*(7-b) +: 8];
    return r;
  endfunction
endpackage

// File: rtl/tce_win_match.sv
module tce_win_match
  import tce_seq_pkg::*;
#(
  parameter int NUM_WIN = 2,
  parameter int CNT_W   = 32,
  localparam int SEL_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic [63:0]            window,
  input  logic [NUM_WIN*32-1:0]  win_ids,
  input  logic [NUM_WIN*CNT_W-1:0] win_sizes,
  input  logic [NUM_WIN*SH_W-1:0]  win_shifts,
  output logic                   hit,
  output logic [SEL_W-1:0]       sel,
  output logic [CNT_W-1:0]       size,
  output logic [SH_W-1:0]        shift
);
  logic [NUM_WIN-1:0] eq;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
    assign eq[w] = (window[31:0] == win_ids[32*w +: 32]);
  end

  // Lowest matching position wins (R11): scan downward so the last write is the lowest.
  always_comb begin
    sel   = '0;
    size  = '0;
    shift = '0;
    for (int w = NUM_WIN-1; w >= 0; w--) begin
      if (eq[w]) begin
        sel   = SEL_W'(w);
        size  = win_sizes[CNT_W*w +: CNT_W];
        shift = win_shifts[SH_W*w +: SH_W];
      end
    end
  end

  assign hit = (|eq) && (window[63:32] == 32'd0);
endmodule

// File: rtl/tce_cmd_check.sv
module tce_cmd_check
  import tce_seq_pkg::*;
#(
  parameter int CNT_W      = 32,
  parameter int MAX_LIST   = 512,
  parameter int LIST_ALIGN = 12
) (
  input  logic              kind,
  input  logic              win_hit,
  input  logic [CNT_W-1:0]  win_size,
  input  logic [CNT_W-1:0]  count,
  input  logic [63:0]       list_addr,
  output logic              bad
);
  logic fill_over, list_over, list_misal, no_pages;

  assign no_pages   = (count == '0);
  assign fill_over  = (kind == KIND_FILL) && (count > win_size);
  assign list_over  = (kind == KIND_LIST) && (count > CNT_W'(MAX_LIST));
  assign list_misal = (kind == KIND_LIST) && (list_addr[LIST_ALIGN-1:0] != '0);
  assign bad        = !win_hit || no_pages || fill_over || list_over || list_misal;
endmodule

// File: rtl/tce_bulk_seq.sv
module tce_bulk_seq
  import tce_seq_pkg::*;
#(
  parameter int NUM_WIN    = 2,
  parameter int CNT_W      = 32,
  parameter int MAX_LIST   = 512,
  parameter int LIST_ALIGN = 12,
  localparam int SEL_W     = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_valid,
  output logic                     cmd_ready,
  input  logic                     cmd_kind,
  input  logic [63:0]              cmd_window,
  input  logic [63:0]              cmd_bus_addr,
  input  logic [63:0]              cmd_operand,
  input  logic [CNT_W-1:0]         cmd_count,
  output logic                     done,
  output logic                     status,
  output logic [CNT_W-1:0]         last_index,
  input  logic [NUM_WIN*32-1:0]    win_ids,
  input  logic [NUM_WIN*CNT_W-1:0] win_sizes,
  input  logic [NUM_WIN*6-1:0]     win_shifts,
  output logic                     tw_en,
  output logic [SEL_W-1:0]         tw_sel,
  output logic [63:0]              tw_addr,
  output logic [63:0]              tw_data,
  input  logic                     tw_err,
  output logic                     rd_req,
  output logic [63:0]              rd_addr,
  input  logic                     rd_ack,
  input  logic                     rd_valid,
  input  logic [63:0]              rd_data
);
  seq_state_e        state_q;
  logic              kind_q, done_q, status_q;
  logic [SEL_W-1:0]  sel_q;
  logic [SH_W-1:0]   shift_q;
  logic [CNT_W-1:0]  cnt_q, idx_q, last_q;
  logic [63:0]       addr_q, oper_q, list_q;

  logic              m_hit, chk_bad;
  logic [SEL_W-1:0]  m_sel;
  logic [CNT_W-1:0]  m_size;
  logic [SH_W-1:0]   m_shift;

  tce_win_match #(.NUM_WIN(NUM_WIN), .CNT_W(CNT_W)) u_match (
    .window(cmd_window), .win_ids(win_ids), .win_sizes(win_sizes),
    .win_shifts(win_shifts), .hit(m_hit), .sel(m_sel), .size(m_size),
    .shift(m_shift)
  );

  tce_cmd_check #(.CNT_W(CNT_W), .MAX_LIST(MAX_LIST), .LIST_ALIGN(LIST_ALIGN)) u_check (
    .kind(cmd_kind), .win_hit(m_hit), .win_size(m_size), .count(cmd_count),
    .list_addr(cmd_operand), .bad(chk_bad)
  );

  // Named events for the assertions.
  logic cmd_take, wr_fault, last_entry;
  assign cmd_take   = (state_q == SQ_IDLE) && cmd_valid;
  assign wr_fault   = tw_en && tw_err;
  assign last_entry = (idx_q == cnt_q - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SQ_IDLE;
      kind_q   <= KIND_FILL;
      done_q   <= 1'b0;
      status_q <= ST_PARAM;
      sel_q    <= '0;
      shift_q  <= '0;
      cnt_q    <= '0;
      idx_q    <= '0;
      last_q   <= '0;
      addr_q   <= '0;
      oper_q   <= '0;
      list_q   <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        SQ_IDLE: if (cmd_valid) begin
          if (chk_bad) begin
            done_q   <= 1'b1;
            status_q <= ST_PARAM;
            last_q   <= '0;
          end else begin
            kind_q  <= cmd_kind;
            sel_q   <= m_sel;
            shift_q <= m_shift;
            cnt_q   <= cmd_count;
            idx_q   <= '0;
            addr_q  <= page_base(cmd_bus_addr, m_shift);
            oper_q  <= cmd_operand;
            list_q  <= cmd_operand;
            state_q <= (cmd_kind == KIND_LIST) ? SQ_REQ : SQ_WRITE;
          end
        end
        SQ_REQ: if (rd_ack) state_q <= SQ_WAIT;
        SQ_WAIT: if (rd_valid) begin
          oper_q  <= byte_rev(rd_data);
          state_q <= SQ_WRITE;
        end
        SQ_WRITE: begin
          if (tw_err) begin
            done_q   <= 1'b1;
            status_q <= ST_PARAM;
            last_q   <= (idx_q == '0) ? '0 : idx_q - 1'b1;
            state_q  <= SQ_IDLE;
          end else if (last_entry) begin
            done_q   <= 1'b1;
            status_q <= ST_OK;
            last_q   <= idx_q;
            state_q  <= SQ_IDLE;
          end else begin
            idx_q   <= idx_q + 1'b1;
            addr_q  <= addr_q + page_step(shift_q);
            list_q  <= list_q + 64'd8;
            state_q <= (kind_q == KIND_LIST) ? SQ_REQ : SQ_WRITE;
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign cmd_ready  = (state_q == SQ_IDLE);
  assign done       = done_q;
  assign status     = status_q;
  assign last_index = last_q;
  assign tw_en      = (state_q == SQ_WRITE);
  assign tw_sel     = sel_q;
  assign tw_addr    = addr_q;
  assign tw_data    = oper_q;
  assign rd_req     = (state_q == SQ_REQ);
  assign rd_addr    = list_q;

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R4
  zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_take && (cmd_count == '0) |=> done && (status == ST_PARAM) && !tw_en);
  // R8
  fault_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fault |=> done && (status == ST_PARAM) && !tw_en);
  // R7
  read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_ack |=> rd_req && $stable(rd_addr));
  // R9
  success_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && (status == ST_OK) |-> last_index == cnt_q - 1'b1);
endmodule

// File: tb/sim_tce_bulk_seq.sv
module sim_tce_bulk_seq;
  localparam int CNT_W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        cmd_valid = 1'b0, cmd_kind = 1'b0;
  logic [63:0] cmd_window = '0, cmd_bus_addr = '0, cmd_operand = '0;
  logic [31:0] cmd_count = '0;
  logic        cmd_ready, done, status;
  logic [31:0] last_index;
  logic        tw_en, tw_err;
  logic [0:0]  tw_sel;
  logic [63:0] tw_addr, tw_data, rd_addr;
  logic        rd_req, rd_ack = 1'b0, rd_valid = 1'b0;
  logic [63:0] rd_data = '0;

  // Bench window configuration.
  localparam logic [31:0] ID0 = 32'h10, ID1 = 32'h22;
  localparam logic [63:0] BASE0 = 64'h0, BASE1 = 64'h10_0000;
  localparam int ENT0 = 8, ENT1 = 4, SH0 = 12, SH1 = 16;

  tce_bulk_seq #(.NUM_WIN(2), .CNT_W(CNT_W)) u0 (
    .clk, .rst_n, .cmd_valid, .cmd_ready, .cmd_kind, .cmd_window, .cmd_bus_addr,
    .cmd_operand, .cmd_count, .done, .status, .last_index,
    .win_ids({ID1, ID0}), .win_sizes({32'(ENT1), 32'(ENT0)}),
    .win_shifts({6'(SH1), 6'(SH0)}),
    .tw_en, .tw_sel, .tw_addr, .tw_data, .tw_err,
    .rd_req, .rd_addr, .rd_ack, .rd_valid, .rd_data
  );

  int checks = 0, errors = 0;
  int wr_cnt = 0, rd_cnt = 0;
  int cyc = 0;

  // Expectations for the current command.
  logic        e_kind;
  logic [63:0] e_start, e_oper;
  int          e_shift, e_sel, e_writes, e_idx;
  logic        e_status;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mem_word(input logic [63:0] a);
    return {a[31:0] ^ 32'hC3A5_0F96, ~a[31:0]};
  endfunction

  // Memory lane order: byte at address a+i sits in bits [8i+7:8i]; value is big-endian.
  function automatic logic [63:0] to_lanes(input logic [63:0] v);
    logic [63:0] r = '0;
    for (int i = 0; i < 8; i++) r = r | ({56'd0, v[63-8*i -: 8]} << (8*i));
    return r;
  endfunction

  function automatic bit tbl_err(input int sel, input logic [63:0] a);
    logic [63:0] base = sel ? BASE1 : BASE0;
    int sh = sel ? SH1 : SH0;
    int ent = sel ? ENT1 : ENT0;
    if (a < base) return 1'b1;
    return ((a - base) >> sh) >= 64'(ent);
  endfunction

  assign tw_err = tw_en && tbl_err(int'(tw_sel), tw_addr);

  // Write monitor: R5 address, R6/R7 data, R11 window select.
  always @(negedge clk) if (rst_n && tw_en) begin
    logic [63:0] xa, xd;
    xa = e_start + (64'(wr_cnt) << e_shift);
    xd = e_kind ? mem_word(e_oper + 64'(8 * wr_cnt)) : e_oper;
    chk(wr_cnt < e_writes, "R8 extra write", 64'(wr_cnt), 64'(e_writes));
    chk(tw_addr == xa, "R5 write address", tw_addr, xa);
    chk(tw_data == xd, e_kind ? "R7 list value" : "R6 fill value", tw_data, xd);
    chk(int'(tw_sel) == e_sel, "R11 window select", 64'(tw_sel), 64'(e_sel));
    wr_cnt++;
  end

  // Memory responder, one request at a time (R7).
  initial begin
    forever begin
      @(negedge clk);
      if (rd_req) begin
        logic [63:0] xa;
        xa = e_oper + 64'(8 * rd_cnt);
        chk(rd_addr == xa, "R7 read address", rd_addr, xa);
        rd_ack = 1'b1;
        @(negedge clk);
        rd_ack = 1'b0;
        chk(!rd_req, "R7 single outstanding", 64'(rd_req), 64'd0);
        repeat (2) @(negedge clk);
        rd_data  = to_lanes(mem_word(rd_addr));
        rd_valid = 1'b1;
        rd_cnt++;
        @(negedge clk);
        rd_valid = 1'b0;
      end
    end
  end

  task automatic run(input logic kind, input logic [63:0] win, input logic [63:0] addr,
                     input logic [63:0] oper, input logic [31:0] n, input string req);
    bit ok;
    int j, sh, ent;
    // Bench model of validation.
    j = -1;
    if (win[63:32] == 32'd0) begin
      if (win[31:0] == ID0) j = 0;
      else if (win[31:0] == ID1) j = 1;
    end
    sh  = (j == 1) ? SH1 : SH0;
    ent = (j == 1) ? ENT1 : ENT0;
    ok = (j >= 0) && (n != 0);
    if (ok && !kind && n > 32'(ent)) ok = 1'b0;
    if (ok && kind && (n > 512 || oper[11:0] != 12'd0)) ok = 1'b0;
    e_kind = kind; e_oper = oper; e_shift = sh; e_sel = (j < 0) ? 0 : j;
    e_start = (addr >> sh) << sh;
    if (!ok) begin
      e_writes = 0; e_status = 1'b1; e_idx = 0;
    end else begin
      e_writes = int'(n); e_status = 1'b0; e_idx = int'(n) - 1;
      for (int k = 0; k < int'(n); k++) begin
        if (tbl_err(j, e_start + (64'(k) << sh))) begin
          e_writes = k + 1; e_status = 1'b1; e_idx = (k == 0) ? 0 : k - 1;
          break;
        end
      end
    end
    wr_cnt = 0; rd_cnt = 0;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    chk(cmd_ready, "R10 ready when idle", 64'(cmd_ready), 64'd1);
    cmd_kind = kind; cmd_window = win; cmd_bus_addr = addr; cmd_operand = oper;
    cmd_count = n; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!done) @(negedge clk);
    chk(status == e_status, {req, " status"}, 64'(status), 64'(e_status));
    chk(last_index == 32'(e_idx), "R9 reported index", 64'(last_index), 64'(e_idx));
    chk(wr_cnt == e_writes, {req, " write count"}, 64'(wr_cnt), 64'(e_writes));
    chk(rd_cnt == (kind ? e_writes : 0), {req, " read count"}, 64'(rd_cnt),
        64'(kind ? e_writes : 0));
    @(negedge clk);
    chk(!done, "R10 done single pulse", 64'(done), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!done && !tw_en && !rd_req, "R10 reset outputs quiet", {61'd0, done, tw_en, rd_req}, 64'd0);
    chk(cmd_ready, "R10 ready after reset", 64'(cmd_ready), 64'd1);
    rst_n = 1'b1;

    // R1: bad windows.
    run(1'b0, 64'h1_0000_0010, 64'h0, 64'h55, 32'd2, "R1 upper bits");
    run(1'b0, 64'h0000_0033, 64'h0, 64'h55, 32'd2, "R1 unknown id");
    run(1'b1, 64'h0000_0011, 64'h0, 64'h4000, 32'd1, "R1 unknown id list");
    // R4: zero count on both kinds.
    run(1'b0, 64'(ID0), 64'h0, 64'h77, 32'd0, "R4 zero fill");
    run(1'b1, 64'(ID1), BASE1, 64'h8000, 32'd0, "R4 zero list");
    // R2/R5/R6/R8/R9: fill sweep over start page and count on window 0.
    for (int s = 0; s < 10; s++)
      for (int n = 0; n < 10; n++)
        run(1'b0, 64'(ID0), 64'(s) * 64'h1000 + 64'h123, 64'hDEAD_0000_0000_0000 | 64'(s * 16 + n),
            32'(n), (n > ENT0) ? "R2 fill limit" : "R8 fill run");
    // R3: list rejects.
    run(1'b1, 64'(ID1), BASE1, 64'h8008, 32'd2, "R3 misaligned list");
    run(1'b1, 64'(ID1), BASE1, 64'h8000, 32'd513, "R3 list over 512");
    run(1'b1, 64'(ID0), 64'h0, 64'h9000, 32'd512, "R3 list of 512 accepted");
    // R7/R8/R9: list sweep on window 1 including a start below the base.
    for (int s = -1; s < 6; s++)
      for (int n = 0; n < 7; n++)
        run(1'b1, 64'(ID1), BASE1 + 64'(s) * 64'h1_0000 + 64'h7F, 64'h4000 * 64'(n + 1),
            32'(n), "R7 list run");
    // R11 via window 1 fill with rounding inside the page.
    run(1'b0, 64'(ID1), BASE1 + 64'h2_FFFF, 64'h1234, 32'd2, "R11 fill window 1");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) cyc++;
  initial begin
    wait (cyc > 150000);
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule